// File: doc/BRIEF.md
# AXI4-Lite to Register Bus Bridge

This block sits between an AXI4-Lite slave port and a peripheral's register file. It turns each AXI4-Lite write or read into a one-cycle request on a plain internal bus: a write strobe or a read strobe, a word address, write data, and on the way back an acknowledge that carries read data. It handles one transaction at a time. It returns the response on the B or R channel and goes back to idle only after the master has taken that response.

When a complete write request and a read request are present in the same cycle, the write is taken and the read waits. The read is not promised fairness. The bridge never compares the address against a window, because the interconnect has already routed the request. If the register side never answers, a watchdog closes the transaction with an error response. The protection inputs and the byte strobes are present only so the port matches the protocol.

Top module: `axil_reg_bridge`

## Requirements
- R1: A write is accepted only in idle and only when `s_awvalid` and `s_wvalid` are both high. `s_awready` and `s_wready` are then high together, for that single cycle only.
- R2: `s_arready` is high only in idle, with `s_arvalid` high, and only when there is no complete write request (`s_awvalid` and `s_wvalid` both high). A lone `s_awvalid` does not block a read. A read waiting beside a write is accepted only after the write response has been taken.
- R3: `reg_addr` is the AXI byte address divided by 4 and truncated to `REG_ADDR_W` bits (default 14). No address is rejected: a byte address of 0xFFFFFFFC becomes word 0x3FFF.
- R4: `reg_wr` (for writes) or `reg_rd` (for reads) is high for exactly one cycle, in the cycle after acceptance. During that cycle `reg_addr` and `reg_wdata` carry the request.
- R5: A `reg_ack` seen in the strobe cycle or in any later waiting cycle raises `s_bvalid` or `s_rvalid` in the next cycle. The response code is OKAY (2'b00), and `s_rdata` is the `reg_rdata` present with the acknowledge.
- R6: If no `reg_ack` arrives in the 32 cycles that start with the strobe cycle, the response is raised in the 33rd cycle with SLVERR (2'b10). A read then returns 0xDEADDEAD.
- R7: While a response is waiting, VALID stays high and the response stays stable until the master's READY. No READY output is raised from acceptance until the cycle after the response handshake.
- R8: `s_awprot`, `s_arprot` and `s_wstrb` have no effect. A write with any strobe value puts the full 32-bit `s_wdata` on `reg_wdata`.
- R9: Reset is synchronous and active-low. While `rst_n` is low, every VALID and READY output is low. After reset the bridge is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | AXI_ADDR_W | Write byte address |
| s_awprot | input | 3 | Write protection (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Byte strobes (ignored) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | AXI_ADDR_W | Read byte address |
| s_arprot | input | 3 | Read protection (ignored) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_addr | output | REG_ADDR_W | Register word address |
| reg_wdata | output | DATA_W | Register write data |
| reg_rdata | input | DATA_W | Register read data, valid with reg_ack |
| reg_ack | input | 1 | Register access acknowledge |

## Verification
The hardest case to reach from the ports is a read that arrives together with a write and must wait through the write's whole life, including a stalled B handshake, before it is taken. A directed sequence holds all three request VALIDs high, delays `s_bready` for two cycles, and checks `s_arready` in every cycle until the read is finally accepted. The watchdog boundary is a second hard case. Random transactions choose acknowledge latencies of 31 (the last accepted cycle) and above (a timeout), and the expected response cycle and code are worked out from the latency in each case.

// File: rtl/axil_bridge_pkg.sv
package axil_bridge_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_RESP} bridge_state_e;
  localparam logic [1:0]  RESP_OKAY   = 2'b00;
  localparam logic [1:0]  RESP_SLVERR = 2'b10;
  localparam logic [31:0] ERR_WORD    = 32'hDEAD_DEAD;
endpackage

// File: rtl/axil_bridge_arb.sv
module axil_bridge_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic aw_v,
  input  logic w_v,
  input  logic ar_v,
  output logic take_wr,
  output logic take_rd
);
  logic wr_pending;
  assign wr_pending = aw_v && w_v;
  // fixed priority: a complete write request always wins
  assign take_wr = idle && wr_pending;
  assign take_rd = idle && ar_v && !wr_pending;

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_wr && take_rd));
endmodule

// File: rtl/axil_bridge_wdog.sv
module axil_bridge_wdog #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic ack,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (start)                cnt_q <= '0;
    else if (run && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && !ack && (cnt_q == LAST);

  assert_count_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ack && !expire && !start) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/axil_reg_bridge.sv
module axil_reg_bridge
  import axil_bridge_pkg::*;
#(
  parameter int AXI_ADDR_W = 32,
  parameter int REG_ADDR_W = 14,
  parameter int DATA_W     = 32,
  parameter int ACK_LIMIT  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_awvalid,
  output logic                  s_awready,
  input  logic [AXI_ADDR_W-1:0] s_awaddr,
  input  logic [2:0]            s_awprot,
  input  logic                  s_wvalid,
  output logic                  s_wready,
  input  logic [DATA_W-1:0]     s_wdata,
  input  logic [DATA_W/8-1:0]   s_wstrb,
  output logic                  s_bvalid,
  input  logic                  s_bready,
  output logic [1:0]            s_bresp,
  input  logic                  s_arvalid,
  output logic                  s_arready,
  input  logic [AXI_ADDR_W-1:0] s_araddr,
  input  logic [2:0]            s_arprot,
  output logic                  s_rvalid,
  input  logic                  s_rready,
  output logic [DATA_W-1:0]     s_rdata,
  output logic [1:0]            s_rresp,
  output logic                  reg_wr,
  output logic                  reg_rd,
  output logic [REG_ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0]     reg_wdata,
  input  logic [DATA_W-1:0]     reg_rdata,
  input  logic                  reg_ack
);
  localparam int LSB = 2;

  function automatic logic [REG_ADDR_W-1:0] to_word(input logic [AXI_ADDR_W-1:0] a);
    return a[REG_ADDR_W+LSB-1:LSB];
  endfunction

  bridge_state_e        state_q;
  logic                 is_wr_q;
  logic [REG_ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]    wdata_q, rdata_q;
  logic [1:0]           resp_q;

  // named internal events
  logic idle, busy, wr_accept, rd_accept, ack_seen, timed_out, resp_done;
  logic ign_unused;

  assign idle      = rst_n && (state_q == ST_IDLE);
  assign busy      = (state_q == ST_REQ) || (state_q == ST_WAIT);
  assign ack_seen  = busy && reg_ack;
  assign resp_done = (state_q == ST_RESP) && (is_wr_q ? s_bready : s_rready);
  assign ign_unused = ^{s_awprot, s_arprot, s_wstrb, s_awaddr, s_araddr};

  axil_bridge_arb u_arb (
    .clk(clk), .rst_n(rst_n), .idle(idle),
    .aw_v(s_awvalid), .w_v(s_wvalid), .ar_v(s_arvalid),
    .take_wr(wr_accept), .take_rd(rd_accept)
  );

  axil_bridge_wdog #(.LIMIT(ACK_LIMIT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .start(wr_accept || rd_accept),
    .run(busy), .ack(reg_ack), .expire(timed_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      resp_q  <= RESP_OKAY;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (wr_accept) begin
            state_q <= ST_REQ;
            is_wr_q <= 1'b1;
            addr_q  <= to_word(s_awaddr);
            wdata_q <= s_wdata;
          end else if (rd_accept) begin
            state_q <= ST_REQ;
            is_wr_q <= 1'b0;
            addr_q  <= to_word(s_araddr);
          end
        end
        ST_REQ, ST_WAIT: begin
          if (ack_seen) begin
            state_q <= ST_RESP;
            resp_q  <= RESP_OKAY;
            rdata_q <= is_wr_q ? '0 : reg_rdata;
          end else if (timed_out) begin
            state_q <= ST_RESP;
            resp_q  <= RESP_SLVERR;
            rdata_q <= DATA_W'(ERR_WORD);
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_RESP: if (resp_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign s_awready = wr_accept;
  assign s_wready  = wr_accept;
  assign s_arready = rd_accept;
  assign s_bvalid  = rst_n && (state_q == ST_RESP) && is_wr_q;
  assign s_rvalid  = rst_n && (state_q == ST_RESP) && !is_wr_q;
  assign s_bresp   = resp_q;
  assign s_rresp   = resp_q;
  assign s_rdata   = rdata_q;
  assign reg_wr    = rst_n && (state_q == ST_REQ) && is_wr_q;
  assign reg_rd    = rst_n && (state_q == ST_REQ) && !is_wr_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;

  assert_wr_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s_awready |-> (s_awvalid && s_wvalid && s_wready));
  assert_rd_yield_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_arready |-> (s_arvalid && !(s_awvalid && s_wvalid)));
  assert_strobe_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_awready || s_arready) |=> $onehot({reg_wr, reg_rd}));
  assert_strobe_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |=> !(reg_wr || reg_rd));
  assert_resp_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_seen |=> ((s_bvalid || s_rvalid) && s_bresp == RESP_OKAY));
  assert_timeout_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |=> ((s_bvalid || s_rvalid) && s_rresp == RESP_SLVERR));
  assert_hold_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));
  assert_hold_r_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));
  assert_busy_no_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid || s_rvalid || reg_wr || reg_rd) |-> !(s_awready || s_arready));
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |-> !(s_awready || s_wready || s_arready || s_bvalid || s_rvalid));
endmodule

// File: tb/sim_axil_reg_bridge.sv
module sim_axil_reg_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0, reg_ack = 0;
  logic [31:0] s_awaddr = 0, s_araddr = 0, s_wdata = 0, reg_rdata = 0;
  logic [2:0]  s_awprot = 0, s_arprot = 0;
  logic [3:0]  s_wstrb = 0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid, reg_wr, reg_rd;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata, reg_wdata;
  logic [13:0] reg_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  axil_reg_bridge u0 (.*);

  function automatic logic [13:0] exp_word(input logic [31:0] a);
    return 14'((a >> 2) % 32'd16384);
  endfunction
  function automatic int resp_cycle(input int lat);
    return (lat < 32) ? lat + 1 : 32;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input bit wr, input logic [31:0] addr, input logic [31:0] data,
                         input int lat, input int hold);
    logic [31:0] rv;
    int vc;
    rv = $urandom;
    vc = resp_cycle(lat);
    @(negedge clk);
    s_awprot = 3'($urandom); s_arprot = 3'($urandom); s_wstrb = 4'($urandom);
    if (wr) begin
      s_awaddr = addr; s_wdata = data; s_awvalid = 1; s_wvalid = 1;
    end else begin
      s_araddr = addr; s_arvalid = 1;
    end
    #1;
    if (wr) chk(s_awready && s_wready && !s_arready, "R1 accept", {s_awready, s_wready}, 2'b11);
    else    chk(s_arready && !s_awready, "R2 accept", s_arready, 1);
    @(posedge clk); @(negedge clk);
    s_awvalid = 0; s_wvalid = 0; s_arvalid = 0;
    chk((wr ? reg_wr : reg_rd) === 1'b1, "R4 strobe", {reg_wr, reg_rd}, wr ? 2 : 1);
    chk(reg_addr == exp_word(addr), "R3 word address", reg_addr, exp_word(addr));
    if (wr) chk(reg_wdata == data, "R8 full word written", reg_wdata, data);
    for (int k = 0; k < vc; k++) begin
      if (k > 0) @(negedge clk);
      reg_ack = (k == lat);
      reg_rdata = (k == lat) ? rv : $urandom;
      if (k == 1) chk(!reg_wr && !reg_rd, "R4 one cycle", {reg_wr, reg_rd}, 0);
      if (k > 0) chk(!s_bvalid && !s_rvalid, "R5 no early response", {s_bvalid, s_rvalid}, 0);
    end
    @(negedge clk);
    reg_ack = 0;
    if (wr) begin
      chk(s_bvalid, "R5 bvalid timing", s_bvalid, 1);
      chk(s_bresp == (lat < 32 ? 2'b00 : 2'b10), "R6 bresp", s_bresp, lat < 32 ? 0 : 2);
    end else begin
      chk(s_rvalid, "R5 rvalid timing", s_rvalid, 1);
      chk(s_rresp == (lat < 32 ? 2'b00 : 2'b10), "R6 rresp", s_rresp, lat < 32 ? 0 : 2);
      chk(s_rdata == (lat < 32 ? rv : 32'hDEADDEAD), "R5 R6 rdata", s_rdata,
          lat < 32 ? rv : 32'hDEADDEAD);
    end
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(wr ? s_bvalid : s_rvalid, "R7 valid held", wr ? s_bvalid : s_rvalid, 1);
    end
    if (wr) s_bready = 1; else s_rready = 1;
    @(negedge clk);
    s_bready = 0; s_rready = 0;
    chk(!s_bvalid && !s_rvalid, "R7 released", {s_bvalid, s_rvalid}, 0);
  endtask

  initial begin
    // R9: reset with all requests pending
    s_awvalid = 1; s_wvalid = 1; s_arvalid = 1; s_bready = 1; s_rready = 1;
    repeat (3) @(negedge clk);
    #1 chk(!s_awready && !s_wready && !s_arready && !s_bvalid && !s_rvalid, "R9 reset quiet",
           {s_awready, s_wready, s_arready, s_bvalid, s_rvalid}, 0);
    s_awvalid = 0; s_wvalid = 0; s_arvalid = 0; s_bready = 0; s_rready = 0;
    @(negedge clk); rst_n = 1;

    // directed corners
    run_txn(1, 32'hFFFF_FFFC, 32'h1234_5678, 0, 0);  // R3 top address
    run_txn(0, 32'h0000_0010, 0, 31, 1);             // R5 last good cycle
    run_txn(0, 32'h0000_0020, 0, 40, 0);             // R6 timeout read
    run_txn(1, 32'h0000_0024, 32'hA5A5_0F0F, 99, 2); // R6 timeout write

    // R2 R7: write and read together, write wins, read waits for B handshake
    @(negedge clk);
    s_awaddr = 32'h40; s_wdata = 32'hCAFE_0001; s_araddr = 32'h84;
    s_awvalid = 1; s_wvalid = 1; s_arvalid = 1;
    #1 chk(s_awready && !s_arready, "R2 write wins", {s_awready, s_arready}, 2'b10);
    @(posedge clk); @(negedge clk);
    s_awvalid = 0; s_wvalid = 0; reg_ack = 1; reg_rdata = 32'h0;
    chk(reg_wr && !s_arready, "R2 read held during write", {reg_wr, s_arready}, 2'b10);
    @(negedge clk); reg_ack = 0;
    chk(s_bvalid && !s_arready, "R7 read held at response", {s_bvalid, s_arready}, 2'b10);
    repeat (2) begin
      @(negedge clk);
      chk(!s_arready, "R7 read held while B stalled", s_arready, 0);
    end
    s_bready = 1;
    #1 chk(!s_arready, "R7 no ready in handshake cycle", s_arready, 0);
    @(negedge clk); s_bready = 0;
    #1 chk(s_arready, "R2 read taken after write", s_arready, 1);
    @(posedge clk); @(negedge clk);
    s_arvalid = 0; reg_ack = 1; reg_rdata = 32'h0BAD_F00D;
    chk(reg_rd && reg_addr == 14'h21, "R3 waiting read address", reg_addr, 14'h21);
    @(negedge clk); reg_ack = 0;
    chk(s_rvalid && s_rdata == 32'h0BAD_F00D, "R5 waiting read data", s_rdata, 32'h0BAD_F00D);
    s_rready = 1; @(negedge clk); s_rready = 0;

    // R2: a lone write address does not block a read
    s_awvalid = 1; s_arvalid = 1; s_araddr = 32'h8;
    #1 chk(s_arready && !s_awready, "R2 lone AW", {s_awready, s_arready}, 2'b01);
    @(posedge clk); @(negedge clk);
    s_awvalid = 0; s_arvalid = 0; reg_ack = 1; reg_rdata = 32'h77;
    @(negedge clk); reg_ack = 0;
    chk(s_rvalid && s_rdata == 32'h77, "R2 lone AW read data", s_rdata, 32'h77);
    s_rready = 1; @(negedge clk); s_rready = 0;

    // random traffic with boundary latencies mixed in
    void'($urandom(32'd20240611));
    for (int i = 0; i < 60; i++) begin
      int lat;
      lat = ($urandom % 6 == 0) ? 30 + int'($urandom % 4) : int'($urandom % 9);
      run_txn(1'($urandom), $urandom, $urandom, lat, int'($urandom % 4));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule